// File: doc/BRIEF.md
# 32-Bit Shift and Rotate Unit with Carry

This block executes one shift or rotate on a single register operand per request. A caller presents an operation code, the operand, a shift count and the current carry flag, and raises a valid strobe. In the same cycle the unit works out the shifted or rotated value and the new carry. On the next clock edge it registers the result together with carry, zero and negative flags. It also raises a one-cycle done pulse at that edge.

There are seven operations. Three are shifts: left logical, right logical and right arithmetic. Two rotate within the 32-bit word, one to the left and one to the right. The last two rotate through the carry flag, so the carry acts as a 33rd bit of the rotated value. Every operation with a non-zero count leaves in the carry the last bit that crossed the register boundary. A count of n always gives the same outcome as n single-step operations.

Top module: `shrot_unit`

## Requirements
- R1: While reset is asserted, and after it is released, result_o is 0, carry_o is 0, zero_o is 1, neg_o is 0 and done_o is 0.
- R2: With op_i = 0 (shift left) and count n > 0, the result is the operand moved up n places with zeros entering at bit 0. The carry is operand bit 32-n.
- R3: With op_i = 1 (logical shift right) and n > 0, the result is the operand moved down n places with zeros entering at bit 31. The carry is operand bit n-1.
- R4: With op_i = 2 (arithmetic shift right) and n > 0, the vacated top positions take copies of the original bit 31. The carry is operand bit n-1.
- R5: With op_i = 3 (rotate left) or op_i = 4 (rotate right) and n > 0, bits leaving one end re-enter at the other end. The carry is the last bit that crossed: result bit 0 for a left rotate, result bit 31 for a right rotate.
- R6: With op_i = 5 (rotate left through carry) or op_i = 6 (rotate right through carry) and n > 0, the 33-bit value {carry_i, operand} is rotated by n. The old carry enters the vacated end. The top bit of the 33-bit result becomes the new carry.
- R7: A count of 0 gives result = operand and carry = carry_i for every operation code.
- R8: zero_o is 1 exactly when the registered result is all zeros. neg_o equals registered result bit 31.
- R9: The result and flags are loaded only on a clock edge where valid_i is 1, and they hold their values otherwise. done_o is 1 in exactly the cycle after each edge where valid_i was 1.
- R10: op_i = 7 passes the operand through as the result and leaves the carry equal to carry_i, whatever the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe; loads the output registers |
| op_i | input | 3 | Operation code (0..7, see requirements) |
| operand_i | input | 32 | Value to shift or rotate |
| count_i | input | 5 | Shift or rotate distance, 0..31 |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Registered new carry flag |
| zero_o | output | 1 | Registered result-is-zero flag |
| neg_o | output | 1 | Registered copy of result bit 31 |
| done_o | output | 1 | One-cycle pulse, one cycle after a request |

## Verification
Every output of the unit passes through exactly one register. The result, carry, zero and negative flags and done for a request sampled at edge k can therefore be read in the half cycle after edge k. The bench drives each request on a falling edge. It samples all outputs on the following falling edge and compares them with a reference model that applies n single-step operations. After some requests the bench leaves the strobe low for a cycle while the inputs change. It then samples again at the falling edge, checking that the outputs held and that done dropped.

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [2:0]           op_i,
  input  logic [W-1:0]         operand_i,
  input  logic [$clog2(W)-1:0] count_i,
  input  logic                 carry_i,
  output logic [W-1:0]         result_o,
  output logic                 carry_o,
  output logic                 zero_o,
  output logic                 neg_o,
  output logic                 done_o
);
  localparam int CW = $clog2(W);

  logic [W:0]     lsl_w, lsr_w, asr_w;
  logic [2*W-1:0] rol_w, ror_w;
  logic [2*W+1:0] rc_dup, rcl_w, rcr_w;
  logic [W:0]     rcl_v, rcr_v;
  logic [W-1:0]   res_c;
  logic           car_c;

  assign lsl_w  = {1'b0, operand_i} << count_i;
  assign lsr_w  = {operand_i, 1'b0} >> count_i;
  assign asr_w  = $unsigned($signed({operand_i, 1'b0}) >>> count_i);
  assign rol_w  = {operand_i, operand_i} << count_i;
  assign ror_w  = {operand_i, operand_i} >> count_i;
  assign rc_dup = {carry_i, operand_i, carry_i, operand_i};
  assign rcl_w  = rc_dup << count_i;
  assign rcr_w  = rc_dup >> count_i;
  assign rcl_v  = rcl_w[2*W+1:W+1];
  assign rcr_v  = rcr_w[W:0];

  always_comb begin
    res_c = operand_i;
    car_c = carry_i;
    if (count_i != '0) begin
      unique case (op_i)
        3'd0: begin res_c = lsl_w[W-1:0];   car_c = lsl_w[W];            end
        3'd1: begin res_c = lsr_w[W:1];     car_c = lsr_w[0];            end
        3'd2: begin res_c = asr_w[W:1];     car_c = asr_w[0];            end
        3'd3: begin res_c = rol_w[2*W-1:W]; car_c = rol_w[W];            end
        3'd4: begin res_c = ror_w[W-1:0];   car_c = ror_w[W-1];          end
        3'd5: begin res_c = rcl_v[W-1:0];   car_c = rcl_v[W];            end
        3'd6: begin res_c = rcr_v[W-1:0];   car_c = rcr_v[W];            end
        default: begin res_c = operand_i;   car_c = carry_i;             end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b1;
      neg_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        result_o <= res_c;
        carry_o  <= car_c;
        zero_o   <= (res_c == '0);
        neg_o    <= res_c[W-1];
      end
    end
  end

  logic [CW-1:0] unused_cw;
  assign unused_cw = '0;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 valid_i,
  input logic [2:0]           op_i,
  input logic [W-1:0]         operand_i,
  input logic [$clog2(W)-1:0] count_i,
  input logic                 carry_i,
  input logic [W-1:0]         result_o,
  input logic                 carry_o,
  input logic                 zero_o,
  input logic                 neg_o,
  input logic                 done_o
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |=>
    (result_o == '0 && !carry_o && zero_o && !neg_o && !done_o));

  p_lsl_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd0 && count_i != '0) |=> result_o[0] == 1'b0);

  p_lsr_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd1 && count_i != '0) |=> result_o[W-1] == 1'b0);

  p_asr_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd2) |=> result_o[W-1] == $past(operand_i[W-1]));

  p_rot_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 3'd3 || op_i == 3'd4)) |=>
      $countones(result_o) == $countones($past(operand_i)));

  p_rc_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == 3'd5 || op_i == 3'd6)) |=>
      $countones({carry_o, result_o}) == $countones({$past(carry_i), $past(operand_i)}));

  p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && count_i == '0) |=>
      (result_o == $past(operand_i) && carry_o == $past(carry_i)));

  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o == (result_o == '0)) && (neg_o == result_o[W-1]));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(result_o) && $stable(carry_o) && !done_o));

  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);

  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 3'd7) |=>
      (result_o == $past(operand_i) && carry_o == $past(carry_i)));
endmodule

bind shrot_unit shrot_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
  .operand_i(operand_i), .count_i(count_i), .carry_i(carry_i),
  .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o),
  .neg_o(neg_o), .done_o(done_o)
);

// File: tb/shrot_unit_tb_top.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] operand_i = '0;
  logic [4:0]  count_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o, zero_o, neg_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  shrot_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .count_i(count_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o),
    .neg_o(neg_o), .done_o(done_o)
  );

  function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input int n, input logic c);
    logic [31:0] r = a;
    logic        cy = c;
    logic        t;
    for (int i = 0; i < n; i++) begin
      case (op)
        3'd0: begin cy = r[31]; r = {r[30:0], 1'b0}; end
        3'd1: begin cy = r[0];  r = {1'b0, r[31:1]}; end
        3'd2: begin cy = r[0];  r = {r[31], r[31:1]}; end
        3'd3: begin cy = r[31]; r = {r[30:0], r[31]}; end
        3'd4: begin cy = r[0];  r = {r[0], r[31:1]}; end
        3'd5: begin t = r[31];  r = {r[30:0], cy}; cy = t; end
        3'd6: begin t = r[0];   r = {cy, r[31:1]}; cy = t; end
        default: ;
      endcase
    end
    return {cy, r};
  endfunction

  function automatic string tag_of(input logic [2:0] op, input int n);
    if (op == 3'd7) return "R10";
    if (n == 0) return "R7";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [31:0] a, input int n,
                        input logic c, input bit idle_after);
    logic [32:0] e;
    string tg;
    e  = model(op, a, n, c);
    tg = tag_of(op, n);
    op_i = op; operand_i = a; count_i = n[4:0]; carry_i = c; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(tg, "result", result_o, e[31:0]);
    check(tg, "carry", {31'b0, carry_o}, {31'b0, e[32]});
    check("R8", "zero", {31'b0, zero_o}, {31'b0, e[31:0] == 32'b0});
    check("R8", "neg", {31'b0, neg_o}, {31'b0, e[31]});
    check("R9", "done", {31'b0, done_o}, 32'd1);
    if (idle_after) begin
      operand_i = ~a; count_i = ~count_i; carry_i = ~c; op_i = op + 3'd1;
      @(negedge clk);
      check("R9", "hold result", result_o, e[31:0]);
      check("R9", "hold carry", {31'b0, carry_o}, {31'b0, e[32]});
      check("R9", "done low", {31'b0, done_o}, 32'd0);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1", "reset result", result_o, 32'd0);
    check("R1", "reset carry", {31'b0, carry_o}, 32'd0);
    check("R1", "reset zero", {31'b0, zero_o}, 32'd1);
    check("R1", "reset neg", {31'b0, neg_o}, 32'd0);
    check("R1", "reset done", {31'b0, done_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after reset result", result_o, 32'd0);
    check("R1", "after reset done", {31'b0, done_o}, 32'd0);

    run_op(3'd0, 32'h8000_0001, 1, 1'b0, 1'b1);
    run_op(3'd0, 32'h0000_0001, 31, 1'b1, 1'b0);
    run_op(3'd1, 32'h0000_0003, 1, 1'b0, 1'b0);
    run_op(3'd1, 32'h8000_0000, 31, 1'b0, 1'b1);
    run_op(3'd2, 32'h8000_0000, 31, 1'b0, 1'b0);
    run_op(3'd2, 32'hC000_0005, 2, 1'b0, 1'b0);
    run_op(3'd3, 32'h8000_0000, 1, 1'b0, 1'b0);
    run_op(3'd4, 32'h0000_0001, 1, 1'b0, 1'b0);
    run_op(3'd5, 32'h8000_0000, 1, 1'b0, 1'b0);
    run_op(3'd5, 32'h0000_0000, 31, 1'b1, 1'b0);
    run_op(3'd6, 32'h0000_0001, 1, 1'b1, 1'b0);
    run_op(3'd6, 32'hFFFF_FFFF, 31, 1'b0, 1'b1);
    for (int op = 0; op < 8; op++) run_op(op[2:0], 32'hDEAD_BEEF, 0, 1'b1, 1'b0);
    run_op(3'd7, 32'h1234_5678, 13, 1'b0, 1'b0);

    for (int k = 0; k < 3000; k++) begin
      run_op($urandom_range(7, 0), $urandom, $urandom_range(31, 0),
             1'($urandom), ($urandom_range(3, 0) == 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule